// File: doc/BRIEF.md
# Tag-Handshake Link-to-System-Bus Bridge Sequencer

This block sits at the receiving end of a cable link and turns link transfers into system-bus commands. The remote master puts a 20-bit address on the link and raises one of two tag lines. The block latches the address and classifies it into one of three regions: memory, I/O, or a small window of local special functions. The remote master then raises the second tag, with write data on the shared lines if the transfer is a write. The order in which the two tags rise selects the direction.

A transfer that needs the system bus first requests mastership. The bus command is issued only when both tags are high and the grant is present. The block answers the link with an acknowledge on whichever comes first: the synchronised bus-slave acknowledge, or a fixed timeout counted in local clock cycles. The timeout means a missing slave can never hang the link. Special functions other than interrupt acknowledge never touch the bus. They produce a one-cycle decoded strobe and are acknowledged at once. The remote master ends every transfer by dropping both tags, and the block then drops its acknowledge and returns to idle.

Top module: `tag_bridge_seq`

## Requirements
- R1: When `tag_a` rises before `tag_b` the transfer is a write; when `tag_b` rises first it is a read. At most one system-bus command output is high at any time.
- R2: An address from 0x00000 to 0xEFFFF issues `mem_wr` (write) or `mem_rd` (read), with `sys_addr` equal to the full latched address.
- R3: An address from 0xF0000 to 0xFFFEF issues `io_wr` or `io_rd`, with `sys_addr` equal to the full latched address.
- R4: An address from 0xFFFF0 to 0xFFFFF is a special function whose offset is address bits 3:0. Offsets 1 to 5 give a one-cycle pulse on `spec_sel` bit (offset), together with `spec_wr` set to the direction and `spec_wdata` set to the data-phase word. None of these offsets requests the bus or issues a bus command. Offsets 6 to 15 are acknowledged with no strobe. A special-function read returns zero.
- R5: Offset 0 (0xFFFF0) is interrupt acknowledge. It requests the bus and drives `sys_inta` as its bus command, in either direction. It also pulses `spec_sel` bit 0 in the cycle the command starts.
- R6: `bus_req` is raised only for memory, I/O and interrupt-acknowledge transfers. A bus command starts only after both tags are high and `bus_grant` is high, and `bus_req` stays high while the command is active.
- R7: The acknowledge follows the bus-slave acknowledge `sys_xack` after a two-flop synchroniser. On a read, `link_bus_out` carries `sys_rdata` and `link_bus_oe` is high while `link_ack` is high. `link_bus_oe` is never high without `link_ack`.
- R8: If `sys_xack` does not arrive within TMO_CYC local cycles of the command start, the command is dropped and `link_ack` is given anyway, and read data is zero. `timeout_err` is then set and stays set until reset.
- R9: `link_ack` stays high until both tags are low and then falls. `bus_req` and all bus commands are low while `link_ack` is high.
- R10: After reset, `link_ack`, `link_bus_oe`, `bus_req`, all commands, `spec_sel` and `timeout_err` are low.
- R11: The data word on `link_bus_in` while both tags are high appears on `sys_wdata`. The top high-address line `link_addr_hi[3]` during that phase is the byte flag and drives `sys_byte`; a byte read returns only `sys_rdata[7:0]`, with the upper byte zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local fast clock |
| rst | input | 1 | Synchronous active-high reset |
| tag_a | input | 1 | Link tag A (first means write) |
| tag_b | input | 1 | Link tag B (first means read) |
| link_addr_hi | input | 4 | High address lines; top bit is the byte flag in the data phase |
| link_bus_in | input | 16 | Shared low address / write data lines from the link |
| link_bus_out | output | 16 | Read data returned to the link |
| link_bus_oe | output | 1 | Drive enable for `link_bus_out` |
| link_ack | output | 1 | Acknowledge to the remote master |
| bus_req | output | 1 | System-bus mastership request |
| bus_grant | input | 1 | System-bus mastership grant |
| sys_addr | output | 20 | Latched system-bus address |
| sys_byte | output | 1 | Byte-wide transfer |
| sys_wdata | output | 16 | System-bus write data |
| sys_rdata | input | 16 | System-bus read data |
| sys_xack | input | 1 | Asynchronous bus-slave transfer acknowledge |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| sys_inta | output | 1 | Interrupt-acknowledge command |
| spec_sel | output | 6 | One-cycle special-function strobes, bit = offset |
| spec_wr | output | 1 | Direction of the special-function access |
| spec_wdata | output | 16 | Data word for the special function |
| timeout_err | output | 1 | Sticky timeout flag |

## Verification
The checker watches the cycle-level invariants all the time. These are: at most one command active, a command starting only after a grant, the request held under every command, no bus activity during a special strobe, the drive enable only with the acknowledge, the acknowledge held while both tags stay high, and the sticky timeout flag. Some behaviours only the bench scenarios can show. These include which command each address region produces, that the region boundaries fall on exactly the right addresses, and which strobe each special offset fires. The same holds for the returned read data, the byte masking, the length of the timeout window, and the fact that the bench delays the grant without the command starting early.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ADDR,
    SQ_CMD,
    SQ_ACK
  } seq_t;

  typedef enum logic [1:0] {
    RG_MEM,
    RG_IO,
    RG_SPEC
  } region_t;

  typedef enum logic [2:0] {
    CM_NONE,
    CM_MRD,
    CM_MWR,
    CM_IORD,
    CM_IOWR,
    CM_INTA
  } cmd_t;

endpackage

// File: rtl/tbs_sync.sv
module tbs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/tbs_addr_decode.sv
module tbs_addr_decode
  import tbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int HI_W   = 4,
  parameter int OFF_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output region_t           region,
  output logic              needs_bus,
  output logic [OFF_W-1:0]  off,
  output cmd_t              cmd
);

  localparam int LO_W = ADDR_W - HI_W;

  logic top_ones;
  logic spec_hit;

  assign top_ones = &addr[ADDR_W-1:LO_W];
  assign spec_hit = &addr[ADDR_W-1:OFF_W];
  assign off      = addr[OFF_W-1:0];

  always_comb begin
    if (spec_hit)      region = RG_SPEC;
    else if (top_ones) region = RG_IO;
    else               region = RG_MEM;
  end

  assign needs_bus = (region != RG_SPEC) || (off == '0);

  always_comb begin
    case (region)
      RG_MEM:  cmd = wr ? CM_MWR : CM_MRD;
      RG_IO:   cmd = wr ? CM_IOWR : CM_IORD;
      RG_SPEC: cmd = (off == '0) ? CM_INTA : CM_NONE;
      default: cmd = CM_NONE;
    endcase
  end

endmodule

// File: rtl/tbs_timeout.sv
module tbs_timeout #(
  parameter int TMO_CYC = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LIMIT);

endmodule

// File: rtl/tag_bridge_seq.sv
module tag_bridge_seq
  import tbs_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int HI_W     = 4,
  parameter int OFF_W    = 4,
  parameter int NUM_SPEC = 6,
  parameter int TMO_CYC  = 192
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tag_a,
  input  logic                       tag_b,
  input  logic [HI_W-1:0]            link_addr_hi,
  input  logic [DATA_W-1:0]          link_bus_in,
  output logic [DATA_W-1:0]          link_bus_out,
  output logic                       link_bus_oe,
  output logic                       link_ack,
  output logic                       bus_req,
  input  logic                       bus_grant,
  output logic [DATA_W+HI_W-1:0]     sys_addr,
  output logic                       sys_byte,
  output logic [DATA_W-1:0]          sys_wdata,
  input  logic [DATA_W-1:0]          sys_rdata,
  input  logic                       sys_xack,
  output logic                       mem_rd,
  output logic                       mem_wr,
  output logic                       io_rd,
  output logic                       io_wr,
  output logic                       sys_inta,
  output logic [NUM_SPEC-1:0]        spec_sel,
  output logic                       spec_wr,
  output logic [DATA_W-1:0]          spec_wdata,
  output logic                       timeout_err
);

  localparam int ADDR_W = DATA_W + HI_W;
  localparam int BYTE_W = 8;

  seq_t              st;
  cmd_t              cmd_q;
  cmd_t              cmd_dec;
  region_t           region;
  logic              needs_bus;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              byte_q;
  logic [2:0]        sync_in;
  logic [2:0]        sync_out;
  logic              ta_s, tb_s, xack_s;
  logic              tmo_exp;
  logic              both_s, none_s;
  logic [NUM_SPEC-1:0] spec_hit;

  // Tags and the bus-slave acknowledge cross into the local clock
  assign sync_in = {sys_xack, tag_b, tag_a};

  tbs_sync #(.W(3), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sync_in),
    .q   (sync_out)
  );

  assign ta_s   = sync_out[0];
  assign tb_s   = sync_out[1];
  assign xack_s = sync_out[2];
  assign both_s = ta_s && tb_s;
  assign none_s = !ta_s && !tb_s;

  tbs_addr_decode #(.ADDR_W(ADDR_W), .HI_W(HI_W), .OFF_W(OFF_W)) u_dec (
    .addr      (addr_q),
    .wr        (wr_q),
    .region    (region),
    .needs_bus (needs_bus),
    .off       (off),
    .cmd       (cmd_dec)
  );

  tbs_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .run     (st == SQ_CMD),
    .expired (tmo_exp)
  );

  // One decoded strobe per special-function offset
  for (genvar k = 0; k < NUM_SPEC; k++) begin : g_spec
    assign spec_hit[k] = (region == RG_SPEC) && (off == OFF_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_IDLE;
      cmd_q       <= CM_NONE;
      addr_q      <= '0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      byte_q      <= 1'b0;
      bus_req     <= 1'b0;
      link_ack    <= 1'b0;
      link_bus_oe <= 1'b0;
      spec_sel    <= '0;
      timeout_err <= 1'b0;
    end else begin
      spec_sel <= '0;
      case (st)
        SQ_IDLE: begin
          if (ta_s || tb_s) begin
            addr_q <= {link_addr_hi, link_bus_in};
            wr_q   <= ta_s;
            st     <= SQ_ADDR;
          end
        end
        SQ_ADDR: begin
          if (none_s) begin
            bus_req <= 1'b0;
            st      <= SQ_IDLE;
          end else begin
            bus_req <= needs_bus;
            if (both_s) begin
              wdata_q <= link_bus_in;
              byte_q  <= link_addr_hi[HI_W-1];
              if (!needs_bus) begin
                spec_sel    <= spec_hit;
                rdata_q     <= '0;
                link_ack    <= 1'b1;
                link_bus_oe <= !wr_q;
                st          <= SQ_ACK;
              end else if (bus_req && bus_grant) begin
                spec_sel <= spec_hit;
                cmd_q    <= cmd_dec;
                st       <= SQ_CMD;
              end
            end
          end
        end
        SQ_CMD: begin
          if (xack_s || tmo_exp) begin
            if (xack_s) begin
              rdata_q <= byte_q ? {{(DATA_W-BYTE_W){1'b0}}, sys_rdata[BYTE_W-1:0]}
                                : sys_rdata;
            end else begin
              rdata_q     <= '0;
              timeout_err <= 1'b1;
            end
            cmd_q       <= CM_NONE;
            bus_req     <= 1'b0;
            link_ack    <= 1'b1;
            link_bus_oe <= !wr_q;
            st          <= SQ_ACK;
          end
        end
        SQ_ACK: begin
          if (none_s) begin
            link_ack    <= 1'b0;
            link_bus_oe <= 1'b0;
            st          <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign mem_rd       = (cmd_q == CM_MRD);
  assign mem_wr       = (cmd_q == CM_MWR);
  assign io_rd        = (cmd_q == CM_IORD);
  assign io_wr        = (cmd_q == CM_IOWR);
  assign sys_inta     = (cmd_q == CM_INTA);
  assign sys_addr     = addr_q;
  assign sys_byte     = byte_q;
  assign sys_wdata    = wdata_q;
  assign spec_wr      = wr_q;
  assign spec_wdata   = wdata_q;
  assign link_bus_out = rdata_q;

endmodule

// File: rtl/tbs_checker.sv
module tbs_checker #(
  parameter int NUM_SPEC = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                tag_a,
  input logic                tag_b,
  input logic                bus_req,
  input logic                bus_grant,
  input logic                mem_rd,
  input logic                mem_wr,
  input logic                io_rd,
  input logic                io_wr,
  input logic                sys_inta,
  input logic                link_ack,
  input logic                link_bus_oe,
  input logic [NUM_SPEC-1:0] spec_sel,
  input logic                timeout_err
);

  logic cmd_any;
  assign cmd_any = mem_rd | mem_wr | io_rd | io_wr | sys_inta;

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr, sys_inta})); // R1

  AST_CMD_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_any) |-> $past(bus_grant)); // R6

  AST_CMD_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    cmd_any |-> bus_req); // R6

  AST_SPEC_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (|spec_sel[NUM_SPEC-1:1]) |-> (!bus_req && !cmd_any)); // R4

  AST_OE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    link_bus_oe |-> link_ack); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> timeout_err); // R8

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (link_ack && tag_a && tag_b) |=> link_ack); // R9

  AST_ACK_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
    link_ack |-> (!cmd_any && !bus_req)); // R9

endmodule

bind tag_bridge_seq tbs_checker #(.NUM_SPEC(NUM_SPEC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tag_a       (tag_a),
  .tag_b       (tag_b),
  .bus_req     (bus_req),
  .bus_grant   (bus_grant),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .sys_inta    (sys_inta),
  .link_ack    (link_ack),
  .link_bus_oe (link_bus_oe),
  .spec_sel    (spec_sel),
  .timeout_err (timeout_err)
);

// File: tb/tb_tag_bridge_seq.sv
`timescale 1ns/1ps
module tb_tag_bridge_seq;

  localparam int TMO = 40;
  localparam int NSP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tag_a = 1'b0, tag_b = 1'b0;
  logic [3:0]  link_addr_hi = '0;
  logic [15:0] link_bus_in = '0;
  logic [15:0] link_bus_out;
  logic        link_bus_oe, link_ack, bus_req;
  logic        bus_grant = 1'b0;
  logic [19:0] sys_addr;
  logic        sys_byte;
  logic [15:0] sys_wdata, sys_rdata;
  logic        sys_xack = 1'b0;
  logic        mem_rd, mem_wr, io_rd, io_wr, sys_inta;
  logic [NSP-1:0] spec_sel;
  logic        spec_wr;
  logic [15:0] spec_wdata;
  logic        timeout_err;

  always #4 clk = ~clk;

  tag_bridge_seq #(.NUM_SPEC(NSP), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .tag_a(tag_a), .tag_b(tag_b),
    .link_addr_hi(link_addr_hi), .link_bus_in(link_bus_in),
    .link_bus_out(link_bus_out), .link_bus_oe(link_bus_oe), .link_ack(link_ack),
    .bus_req(bus_req), .bus_grant(bus_grant), .sys_addr(sys_addr),
    .sys_byte(sys_byte), .sys_wdata(sys_wdata), .sys_rdata(sys_rdata),
    .sys_xack(sys_xack), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .sys_inta(sys_inta), .spec_sel(spec_sel), .spec_wr(spec_wr),
    .spec_wdata(spec_wdata), .timeout_err(timeout_err)
  );

  // Bus-slave and arbiter models
  logic       resp_en = 1'b1;
  int         gdelay = 0;
  int         gcnt;
  logic       cmd_any;
  assign cmd_any   = mem_rd | mem_wr | io_rd | io_wr | sys_inta;
  assign sys_rdata = sys_addr[15:0] ^ 16'h5A3C;

  always @(posedge clk) begin
    sys_xack <= resp_en && cmd_any;
    if (!bus_req) begin
      gcnt <= 0;
      bus_grant <= 1'b0;
    end else if (gcnt >= gdelay) begin
      bus_grant <= 1'b1;
    end else begin
      gcnt <= gcnt + 1;
    end
  end

  // Monitor
  logic           mon_clr = 1'b0;
  logic [4:0]     seen_cmd;
  logic           seen_req, seen_nogrant, cap_byte, cap_spec_wr;
  logic [NSP-1:0] seen_spec;
  logic [19:0]    cap_addr;
  logic [15:0]    cap_wd, cap_spec_wd;
  int             cmd_cycles;

  always @(posedge clk) begin
    if (mon_clr) begin
      seen_cmd <= '0; seen_req <= 1'b0; seen_nogrant <= 1'b0; seen_spec <= '0;
      cap_addr <= '0; cap_wd <= '0; cap_byte <= 1'b0; cap_spec_wr <= 1'b0;
      cap_spec_wd <= '0; cmd_cycles <= 0;
    end else begin
      seen_cmd <= seen_cmd | {sys_inta, io_wr, io_rd, mem_wr, mem_rd};
      if (bus_req) seen_req <= 1'b1;
      if (cmd_any && !bus_grant) seen_nogrant <= 1'b1;
      if (cmd_any) begin
        cap_addr <= sys_addr; cap_wd <= sys_wdata; cap_byte <= sys_byte;
        cmd_cycles <= cmd_cycles + 1;
      end
      if (|spec_sel) begin
        seen_spec <= seen_spec | spec_sel;
        cap_spec_wr <= spec_wr; cap_spec_wd <= spec_wdata;
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [15:0] rd_val;
  logic        rd_oe;
  logic        got_ack;

  task automatic xfer(input logic [19:0] addr, input bit wr, input logic [15:0] wd,
                      input bit bytef);
    @(negedge clk);
    mon_clr = 1'b1;
    link_addr_hi = addr[19:16];
    link_bus_in  = addr[15:0];
    @(negedge clk);
    mon_clr = 1'b0;
    @(negedge clk);
    if (wr) tag_a = 1'b1; else tag_b = 1'b1;
    repeat (3) @(negedge clk);
    link_bus_in = wr ? wd : 16'h0000;
    link_addr_hi[3] = bytef;
    tag_a = 1'b1; tag_b = 1'b1;
    got_ack = 1'b0;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (link_ack) begin
        got_ack = 1'b1;
        rd_val = link_bus_out;
        rd_oe  = link_bus_oe;
        break;
      end
    end
    tag_a = 1'b0; tag_b = 1'b0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (!link_ack) break;
    end
    chk(!link_ack, "R9 ack released after tags drop", link_ack, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!link_ack && !link_bus_oe && !bus_req, "R10 reset idle link", {link_ack, link_bus_oe, bus_req}, 0);
    chk(!cmd_any && spec_sel == 0 && !timeout_err, "R10 reset idle bus", {cmd_any, spec_sel, timeout_err}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // Sweep: region boundaries and every special offset, both directions
    for (int i = 0; i < 22; i++) begin
      for (int d = 0; d < 2; d++) begin
        logic [19:0] a;
        logic [15:0] wd;
        logic [3:0]  off;
        bit spec, mem, needs;
        logic [4:0]  ecmd;
        logic [NSP-1:0] espec;
        case (i)
          0: a = 20'h00000; 1: a = 20'h12345; 2: a = 20'hEFFFF;
          3: a = 20'hF0000; 4: a = 20'hF8ABC; 5: a = 20'hFFFEF;
          default: a = 20'hFFFF0 + 20'(i - 6);
        endcase
        wd      = a[15:0] ^ 16'hC3C3 ^ 16'(i * 7 + d);
        gdelay  = (i % 4) * 5;
        xfer(a, d == 1, wd, 1'b0);
        mem   = (a <= 20'hEFFFF);
        spec  = (a >= 20'hFFFF0);
        off   = a[3:0];
        needs = !spec || (off == 0);
        if (spec) ecmd = (off == 0) ? 5'b10000 : 5'b00000;
        else if (mem) ecmd = (d == 1) ? 5'b00010 : 5'b00001;
        else ecmd = (d == 1) ? 5'b01000 : 5'b00100;
        espec = (spec && off < NSP) ? NSP'(1) << off : '0;
        chk(got_ack, "R7 ack received", got_ack, 1);
        chk(seen_cmd == ecmd, mem ? "R2 memory command" : (spec ? "R5 inta command" : "R3 io command"), seen_cmd, ecmd);
        chk(seen_req == needs, spec ? "R4 special request" : "R6 bus request", seen_req, needs);
        chk(!seen_nogrant, "R6 command before grant", seen_nogrant, 0);
        chk(seen_spec == espec, off == 0 ? "R5 strobe" : "R4 strobe", seen_spec, espec);
        chk(rd_oe == (d == 0), "R1 direction drive", rd_oe, d == 0);
        if (needs) begin
          chk(cap_addr == a, "R2 R3 bus address", cap_addr, a);
          if (d == 1) chk(cap_wd == wd, "R11 write data", cap_wd, wd);
          else chk(rd_val == (a[15:0] ^ 16'h5A3C), "R7 read data", rd_val, a[15:0] ^ 16'h5A3C);
        end else if (espec != 0) begin
          chk(cap_spec_wr == (d == 1), "R4 special direction", cap_spec_wr, d == 1);
          if (d == 1) chk(cap_spec_wd == wd, "R4 special data", cap_spec_wd, wd);
          else chk(rd_val == 0, "R4 special read zero", rd_val, 0);
        end else if (d == 0) begin
          chk(rd_val == 0, "R4 unused offset read zero", rd_val, 0);
        end
      end
    end
    chk(!timeout_err, "R8 no error without timeout", timeout_err, 0);

    // Byte transfers
    xfer(20'h0A5F7, 1'b0, 16'h0, 1'b1);
    chk(cap_byte == 1'b1, "R11 byte flag read", cap_byte, 1);
    chk(rd_val == {8'h00, 8'hF7 ^ 8'h3C}, "R11 byte read masking", rd_val, {8'h00, 8'hF7 ^ 8'h3C});
    xfer(20'hF1234, 1'b1, 16'hBEEF, 1'b1);
    chk(cap_byte == 1'b1, "R11 byte flag write", cap_byte, 1);
    xfer(20'h01234, 1'b1, 16'hBEEF, 1'b0);
    chk(cap_byte == 1'b0, "R11 word flag", cap_byte, 0);

    // Timeout
    resp_en = 1'b0;
    xfer(20'h00100, 1'b0, 16'h0, 1'b0);
    chk(got_ack, "R8 ack on timeout", got_ack, 1);
    chk(timeout_err, "R8 error set", timeout_err, 1);
    chk(cmd_cycles >= TMO && cmd_cycles <= TMO + 2, "R8 timeout window", cmd_cycles, TMO + 1);
    chk(rd_val == 0, "R8 timeout read zero", rd_val, 0);
    resp_en = 1'b1;
    xfer(20'h00200, 1'b0, 16'h0, 1'b0);
    chk(timeout_err, "R8 error sticky", timeout_err, 1);
    chk(rd_val == (16'h0200 ^ 16'h5A3C), "R7 read after timeout", rd_val, 16'h0200 ^ 16'h5A3C);

    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!timeout_err && !link_ack, "R10 reset clears error", {timeout_err, link_ack}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule